// File: doc/BRIEF.md
# Serial Port Transmit/Receive FIFO Pair

This block holds the characters passing between a host and a serial line. A transmit queue accepts bytes from the host and offers them to a serializer. A receive queue accepts characters from a deserializer, each stored with its line error tags, and offers them to the host. The serializer, the deserializer, baud timing and register decoding live outside the block. Configuration arrives as plain inputs from a register bank.

Each queue has its own watermark, set as a fraction of the queue's capacity. It drives a level interrupt: the receive interrupt means there is enough data to fetch, and the transmit interrupt means there is room to refill. When queuing is switched off, each side shrinks to a single holding slot. A test mode lets software reach the far side of each queue. Through the test port it can load receive entries directly and drain transmit bytes directly.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both queues are empty. flag_tx_empty and flag_rx_empty read 1, flag_tx_full, flag_rx_full and flag_busy read 0, irq_tx reads 1, irq_rx reads 0, and the read-data outputs read 0.
- R2: With cfg_fifo_en=1 each queue holds DEPTH (16) entries and pops them in push order. A full flag rises at DEPTH entries, and a transmit push into a full queue is dropped.
- R3: With cfg_fifo_en=0 each queue holds one entry, and the full flag rises as soon as that entry is stored.
- R4: A receive entry is 12 bits: data in [7:0], framing error in [8], parity error in [9], break error in [10], overrun in [11]. des_rx_err bit 0 is framing, bit 1 is parity and bit 2 is break.
- R5: A receive push into a full queue is discarded. It sets bit 11 of the most recently stored entry and leaves the occupancy unchanged.
- R6: irq_rx is 1 exactly when 4 x occupancy >= q x capacity. Here q is the receive level code (1 = quarter, 2 = half, 3 = three quarters) and capacity is DEPTH or 1.
- R7: irq_tx is 1 exactly when 4 x occupancy <= q x capacity, with q the transmit level code.
- R8: Level codes 0 and 4 to 7 act as code 2 (half).
- R9: Popping an empty queue returns 0 and moves no pointer, so a later push is read back correctly.
- R10: With cfg_test_mode=1, tst_wr pushes the 12-bit tst_wdata into the receive queue, and tst_rdata shows the transmit head while tst_rd pops it. In this mode des_rx_push and ser_tx_pop are ignored.
- R11: With cfg_test_mode=0, tst_wr and tst_rd have no effect and tst_rdata reads 0.
- R12: flag_busy is 1 while the transmit queue is non-empty or ser_active is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fifo_en | input | 1 | 1 = DEPTH-entry queues, 0 = single holding slot |
| cfg_tx_lvl | input | 3 | Transmit watermark code |
| cfg_rx_lvl | input | 3 | Receive watermark code |
| cfg_test_mode | input | 1 | Routes the test port to the far side of each queue |
| host_tx_wr | input | 1 | Host push strobe for the transmit queue |
| host_tx_data | input | 8 | Host transmit byte |
| ser_tx_pop | input | 1 | Serializer pop strobe |
| ser_tx_data | output | 8 | Transmit head byte, 0 when empty |
| ser_active | input | 1 | Serializer is still shifting a character |
| des_rx_push | input | 1 | Deserializer push strobe |
| des_rx_data | input | 8 | Received byte |
| des_rx_err | input | 3 | Break, parity, framing tags (bits 2..0) |
| host_rx_rd | input | 1 | Host pop strobe for the receive queue |
| host_rx_entry | output | 12 | Receive head entry, 0 when empty |
| tst_wr | input | 1 | Test push into the receive queue |
| tst_wdata | input | 12 | Test receive entry |
| tst_rd | input | 1 | Test pop from the transmit queue |
| tst_rdata | output | 8 | Transmit head seen through the test port |
| flag_tx_empty | output | 1 | Transmit queue empty |
| flag_tx_full | output | 1 | Transmit queue full |
| flag_rx_empty | output | 1 | Receive queue empty |
| flag_rx_full | output | 1 | Receive queue full |
| flag_busy | output | 1 | Transmit activity pending |
| irq_tx | output | 1 | Transmit level interrupt |
| irq_rx | output | 1 | Receive level interrupt |

## Verification
Several rules are checked on every cycle: an empty receive queue never raises its interrupt, an empty transmit queue always does, and busy follows pending transmit data. Also checked each cycle: a refused push keeps a full queue full, popping an empty queue changes nothing, and a test-port write is inert outside test mode. Other behaviour is shown only by the directed scenarios: the exact watermark crossings for each level code, first-in-first-out order, the error-tag layout, the overrun tag landing on the newest entry, and the side swap in test mode.

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_fifo_en,
  input  logic [2:0]  cfg_tx_lvl,
  input  logic [2:0]  cfg_rx_lvl,
  input  logic        cfg_test_mode,
  input  logic        host_tx_wr,
  input  logic [7:0]  host_tx_data,
  input  logic        ser_tx_pop,
  output logic [7:0]  ser_tx_data,
  input  logic        ser_active,
  input  logic        des_rx_push,
  input  logic [7:0]  des_rx_data,
  input  logic [2:0]  des_rx_err,
  input  logic        host_rx_rd,
  output logic [11:0] host_rx_entry,
  input  logic        tst_wr,
  input  logic [11:0] tst_wdata,
  input  logic        tst_rd,
  output logic [7:0]  tst_rdata,
  output logic        flag_tx_empty,
  output logic        flag_tx_full,
  output logic        flag_rx_empty,
  output logic        flag_rx_full,
  output logic        flag_busy,
  output logic        irq_tx,
  output logic        irq_rx
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int TW = CW + 2;

  function automatic logic [2:0] quarters(input logic [2:0] code);
    return (code == 3'd1 || code == 3'd2 || code == 3'd3) ? code : 3'd2;
  endfunction

  logic [CW-1:0] cap;
  assign cap = cfg_fifo_en ? CW'(DEPTH) : CW'(1);

  // transmit side
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_rd, tx_wr;
  logic [CW-1:0] tx_cnt;
  logic          tx_pop_req, tx_do_pop, tx_do_push;
  logic [7:0]    tx_head;

  assign flag_tx_empty = (tx_cnt == '0);
  assign flag_tx_full  = (tx_cnt >= cap);
  assign tx_pop_req    = cfg_test_mode ? tst_rd : ser_tx_pop;
  assign tx_do_pop     = tx_pop_req && !flag_tx_empty;
  assign tx_do_push    = host_tx_wr && (!flag_tx_full || tx_do_pop);
  assign tx_head       = flag_tx_empty ? 8'h00 : tx_mem[tx_rd];
  assign ser_tx_data   = tx_head;
  assign tst_rdata     = cfg_test_mode ? tx_head : 8'h00;
  assign flag_busy     = !flag_tx_empty || ser_active;

  always_ff @(posedge clk) begin
    if (tx_do_push) tx_mem[tx_wr] <= host_tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rd  <= '0;
      tx_wr  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_do_push) tx_wr <= tx_wr + AW'(1);
      if (tx_do_pop)  tx_rd <= tx_rd + AW'(1);
      tx_cnt <= tx_cnt + CW'(tx_do_push) - CW'(tx_do_pop);
    end
  end

  // receive side
  logic [11:0]   rx_mem [DEPTH];
  logic [AW-1:0] rx_rd, rx_wr;
  logic [CW-1:0] rx_cnt;
  logic          rx_push_req, rx_do_pop, rx_do_push, rx_ovr;
  logic [11:0]   rx_push_data;

  assign flag_rx_empty = (rx_cnt == '0);
  assign flag_rx_full  = (rx_cnt >= cap);
  assign rx_push_req   = cfg_test_mode ? tst_wr : des_rx_push;
  assign rx_push_data  = cfg_test_mode ? tst_wdata : {1'b0, des_rx_err, des_rx_data};
  assign rx_do_pop     = host_rx_rd && !flag_rx_empty;
  assign rx_do_push    = rx_push_req && (!flag_rx_full || rx_do_pop);
  assign rx_ovr        = rx_push_req && flag_rx_full && !rx_do_pop;
  assign host_rx_entry = flag_rx_empty ? 12'h000 : rx_mem[rx_rd];

  always_ff @(posedge clk) begin
    if (rx_do_push)  rx_mem[rx_wr] <= rx_push_data;
    else if (rx_ovr) rx_mem[rx_wr - AW'(1)][11] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rd  <= '0;
      rx_wr  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_do_push) rx_wr <= rx_wr + AW'(1);
      if (rx_do_pop)  rx_rd <= rx_rd + AW'(1);
      rx_cnt <= rx_cnt + CW'(rx_do_push) - CW'(rx_do_pop);
    end
  end

  // watermarks, compared at four times the occupancy
  logic [TW-1:0] tx_thr, rx_thr;
  assign tx_thr = TW'(quarters(cfg_tx_lvl)) * TW'(cap);
  assign rx_thr = TW'(quarters(cfg_rx_lvl)) * TW'(cap);
  assign irq_tx = ({tx_cnt, 2'b00} <= tx_thr);
  assign irq_rx = ({rx_cnt, 2'b00} >= rx_thr);

  AST_RX_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rx_empty |-> !irq_rx); // R6
  AST_TX_IRQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_tx_empty |-> irq_tx); // R7
  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_tx_full && host_tx_wr && !tx_pop_req) |=> (tx_cnt == $past(tx_cnt))); // R2
  AST_RX_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rx_full && rx_push_req && !host_rx_rd) |=> flag_rx_full); // R5
  AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rx_empty && host_rx_rd && !rx_push_req) |=> flag_rx_empty); // R9
  AST_TEST_OFF_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_test_mode && tst_wr && !des_rx_push && !host_rx_rd) |=> $stable(rx_cnt)); // R11
  AST_BUSY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_tx_empty |-> flag_busy); // R12
endmodule

// File: tb/uart_fifo_pair_test.sv
module uart_fifo_pair_test;
  logic clk = 0, rst_n = 0;
  logic cfg_fifo_en = 1, cfg_test_mode = 0;
  logic [2:0] cfg_tx_lvl = 3'd2, cfg_rx_lvl = 3'd2;
  logic host_tx_wr = 0, ser_tx_pop = 0, ser_active = 0, des_rx_push = 0;
  logic host_rx_rd = 0, tst_wr = 0, tst_rd = 0;
  logic [7:0] host_tx_data = 0, des_rx_data = 0;
  logic [2:0] des_rx_err = 0;
  logic [11:0] tst_wdata = 0;
  logic [7:0] ser_tx_data, tst_rdata;
  logic [11:0] host_rx_entry;
  logic flag_tx_empty, flag_tx_full, flag_rx_empty, flag_rx_full, flag_busy, irq_tx, irq_rx;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  uart_fifo_pair uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk); host_tx_wr = 1; host_tx_data = d;
    @(negedge clk); host_tx_wr = 0;
  endtask
  task automatic pop_tx();
    @(negedge clk); ser_tx_pop = 1;
    @(negedge clk); ser_tx_pop = 0;
  endtask
  task automatic push_rx(input logic [7:0] d, input logic [2:0] e);
    @(negedge clk); des_rx_push = 1; des_rx_data = d; des_rx_err = e;
    @(negedge clk); des_rx_push = 0;
  endtask
  task automatic pop_rx();
    @(negedge clk); host_rx_rd = 1;
    @(negedge clk); host_rx_rd = 0;
  endtask
  task automatic tst_push(input logic [11:0] d);
    @(negedge clk); tst_wr = 1; tst_wdata = d;
    @(negedge clk); tst_wr = 0;
  endtask
  task automatic tst_pop();
    @(negedge clk); tst_rd = 1;
    @(negedge clk); tst_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 tx_empty", flag_tx_empty, 1);
    chk("R1 rx_empty", flag_rx_empty, 1);
    chk("R1 full/busy", {flag_tx_full, flag_rx_full, flag_busy}, 0);
    chk("R1 irq", {irq_tx, irq_rx}, 2'b10);
    chk("R1 data", {ser_tx_data, host_rx_entry, tst_rdata}, 0);
  endtask

  task automatic t_tx_fill();
    cfg_fifo_en = 1; cfg_tx_lvl = 3'd2;
    for (int i = 0; i < 16; i++) begin
      push_tx(8'(8'h10 + i));
      if (i == 7) chk("R7 irq_tx at 8", irq_tx, 1);
      if (i == 8) chk("R7 irq_tx at 9", irq_tx, 0);
    end
    chk("R2 tx_full", flag_tx_full, 1);
    chk("R12 busy", flag_busy, 1);
    push_tx(8'hEE);
    for (int i = 0; i < 16; i++) begin
      chk("R2 tx order", ser_tx_data, 8'(8'h10 + i));
      pop_tx();
    end
    chk("R2 extra dropped", flag_tx_empty, 1);
    chk("R12 idle", flag_busy, 0);
    ser_active = 1; #1;
    chk("R12 ser_active", flag_busy, 1);
    ser_active = 0;
  endtask

  task automatic t_rx_level();
    cfg_rx_lvl = 3'd1;
    for (int i = 0; i < 3; i++) push_rx(8'(i), 3'd0);
    chk("R6 quarter below", irq_rx, 0);
    push_rx(8'd3, 3'd0);
    chk("R6 quarter reached", irq_rx, 1);
    cfg_rx_lvl = 3'd0; #1;
    chk("R8 code0 half", irq_rx, 0);
    cfg_rx_lvl = 3'd5;
    for (int i = 4; i < 8; i++) push_rx(8'(i), 3'd0);
    chk("R8 code5 half", irq_rx, 1);
    cfg_rx_lvl = 3'd3; #1;
    chk("R6 three quarters below", irq_rx, 0);
    cfg_tx_lvl = 3'd7; #1;
    chk("R8 tx code7", irq_tx, 1);
    for (int i = 0; i < 8; i++) pop_rx();
    chk("R6 drained", {flag_rx_empty, irq_rx}, 2'b10);
    cfg_rx_lvl = 3'd2; cfg_tx_lvl = 3'd2;
  endtask

  task automatic t_rx_overrun();
    for (int i = 0; i < 16; i++) push_rx(8'(8'h30 + i), 3'(i));
    chk("R2 rx_full", flag_rx_full, 1);
    push_rx(8'hAA, 3'd0);
    chk("R5 still full", flag_rx_full, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R4 R5 entry", host_rx_entry,
          {(i == 15) ? 1'b1 : 1'b0, 3'(i), 8'(8'h30 + i)});
      pop_rx();
    end
    chk("R5 discarded", flag_rx_empty, 1);
  endtask

  task automatic t_hold();
    cfg_fifo_en = 0; #1;
    push_tx(8'h5C);
    chk("R3 tx full at 1", flag_tx_full, 1);
    chk("R7 hold irq_tx", irq_tx, 0);
    push_tx(8'h5D);
    chk("R3 tx kept", ser_tx_data, 8'h5C);
    pop_tx();
    chk("R3 tx empty", flag_tx_empty, 1);
    push_rx(8'h41, 3'b010);
    chk("R3 rx full irq", {flag_rx_full, irq_rx}, 2'b11);
    push_rx(8'h42, 3'b000);
    chk("R5 hold overrun", host_rx_entry, 12'hA41);
    pop_rx();
    chk("R3 rx empty", flag_rx_empty, 1);
    cfg_fifo_en = 1;
  endtask

  task automatic t_empty_pop();
    pop_rx();
    chk("R9 empty read", host_rx_entry, 0);
    pop_tx();
    chk("R9 tx empty read", ser_tx_data, 0);
    push_rx(8'h99, 3'b100);
    chk("R9 after empty pop", host_rx_entry, 12'h499);
    pop_rx();
    chk("R9 drained", flag_rx_empty, 1);
  endtask

  task automatic t_test_mode();
    push_tx(8'h11); push_tx(8'h22);
    cfg_test_mode = 1; #1;
    chk("R10 tst head", tst_rdata, 8'h11);
    pop_tx();
    chk("R10 ser pop ignored", tst_rdata, 8'h11);
    tst_pop();
    chk("R10 tst pop", tst_rdata, 8'h22);
    tst_push(12'h5A3);
    chk("R10 tst push", host_rx_entry, 12'h5A3);
    push_rx(8'h77, 3'd0);
    pop_rx();
    chk("R10 des push ignored", flag_rx_empty, 1);
    tst_pop();
    chk("R10 tx drained", flag_tx_empty, 1);
    cfg_test_mode = 0;
    tst_push(12'h123);
    chk("R11 tst_wr inert", flag_rx_empty, 1);
    push_tx(8'h33);
    chk("R11 tst_rdata zero", tst_rdata, 0);
    tst_pop();
    chk("R11 tst_rd inert", ser_tx_data, 8'h33);
    pop_tx();
    chk("R11 tx empty", flag_tx_empty, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_fill();
    t_rx_level();
    t_rx_overrun();
    t_hold();
    t_empty_pop();
    t_test_mode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule